// File: doc/BRIEF.md
# Dynamic Round and Saturate Unit

This unit sits at the tail of a multiplier-adder datapath and post-processes a 44-bit signed result. A two-bit selector takes the operand from one of four upstream stages. The operand then passes through an optional rounding step and an optional clamping step, always in that order. Two run-time control bits switch the steps on and off independently of each other.

Rounding is round-half-up at a fixed bit position set by `ROUND_BIT`. Clamping limits the value to the range of a signed `SAT_WIDTH`-bit number, sign-extended back to 44 bits. A flag marks every cycle in which clamping changed the value. The processed value and the flag leave through one output register, which a synchronous reset clears.

Top module: `round_sat_unit`

## Requirements
- R1: `srcSel` picks the operand: 0 = `prodIn`, 1 = `sum1In`, 2 = `pipeIn`, 3 = `sum2In`. The unselected sources have no effect on the outputs.
- R2: With `roundEn`=0 and `satEn`=0, `result` equals the selected operand unchanged and `satFlag` is 0.
- R3: With `roundEn`=1 and `satEn`=0, `result` is the operand plus 2^(ROUND_BIT-1), with bits ROUND_BIT-1..0 then cleared and the sum wrapped to 44 bits. The defaults are ROUND_BIT=8 and SAT_WIDTH=32.
- R4: With `satEn`=1, an operand above 2^(SAT_WIDTH-1)-1 gives that maximum, and an operand below -2^(SAT_WIDTH-1) gives that minimum. Both limits are sign-extended to 44 bits, and `satFlag` is 1 in these cases.
- R5: `satFlag` is 0 whenever no clamping takes place, including whenever `satEn`=0.
- R6: With both enables at 1, rounding is applied first and its sum is kept at 45 bits. A carry out of the 44-bit range is therefore clamped to the positive limit rather than wrapped.
- R7: Results are registered: inputs present before a rising clock edge show up on `result` and `satFlag` right after that edge and not earlier.
- R8: When `rst` is high at a rising edge, `result` and `satFlag` become 0 at that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prodIn | input | 44 | Independent multiplier product |
| sum1In | input | 44 | First adder sum |
| pipeIn | input | 44 | Pipeline register value |
| sum2In | input | 44 | Second adder / accumulator sum |
| srcSel | input | 2 | Operand source select |
| roundEn | input | 1 | Enable rounding |
| satEn | input | 1 | Enable saturation |
| result | output | 44 | Processed result (registered) |
| satFlag | output | 1 | Clamping occurred this cycle (registered) |

## Verification
Every result is due exactly one rising edge after its inputs are applied, since only the output register lies between the inputs and the outputs. The bench drives inputs on a falling edge. It then checks 1 ns later that the outputs still hold the previous result, and checks the new result at the next falling edge. The reset check follows the same timing: the outputs must keep their value while `rst` is high before the edge and read zero one falling edge later.

// File: rtl/round_sat_pkg.sv
package round_sat_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  typedef struct packed {
    logic               doRound;
    logic               doSat;
    logic [NUM_SRC-1:0] srcHot;
  } rs_strobe_t;
endpackage

// File: rtl/round_sat_ctrl.sv
module round_sat_ctrl
  import round_sat_pkg::*;
(
  input  logic [SEL_W-1:0] srcSel,
  input  logic             roundEn,
  input  logic             satEn,
  output rs_strobe_t       strobe
);
  always_comb begin
    strobe.doRound = roundEn;
    strobe.doSat   = satEn;
    strobe.srcHot  = NUM_SRC'(1) << srcSel;
  end
endmodule

// File: rtl/round_sat_dp.sv
module round_sat_dp
  import round_sat_pkg::*;
#(
  parameter int DATA_W    = 44,
  parameter int ROUND_BIT = 8,
  parameter int SAT_WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] srcArr [NUM_SRC],
  input  rs_strobe_t        strobe,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic signed [EXT_W-1:0] HALF    = EXT_W'(1) << (ROUND_BIT - 1);
  localparam logic [EXT_W-1:0]        LOWMASK = (EXT_W'(1) << ROUND_BIT) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] SAT_MAX = (EXT_W'(1) << (SAT_WIDTH - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] SAT_MIN = -(EXT_W'(1) << (SAT_WIDTH - 1));

  logic [DATA_W-1:0]        picked;
  logic signed [EXT_W-1:0]  extVal;
  logic signed [EXT_W-1:0]  roundedVal;
  logic signed [EXT_W-1:0]  clampedVal;
  logic                     clampHit;
  logic [DATA_W-1:0]        nextResult;

  // one-hot OR multiplexer over the source stages
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.srcHot[i]) picked = picked | srcArr[i];
    end
  end

  // rounding stage, one guard bit so a carry is kept for saturation
  always_comb begin
    extVal = {picked[DATA_W-1], picked};
    if (strobe.doRound) roundedVal = (extVal + HALF) & ~LOWMASK;
    else                roundedVal = extVal;
  end

  // saturation stage
  always_comb begin
    clampHit   = 1'b0;
    clampedVal = roundedVal;
    if (roundedVal > SAT_MAX) begin
      clampedVal = SAT_MAX;
      clampHit   = 1'b1;
    end else if (roundedVal < SAT_MIN) begin
      clampedVal = SAT_MIN;
      clampHit   = 1'b1;
    end
    nextResult = strobe.doSat ? clampedVal[DATA_W-1:0] : roundedVal[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      satFlag <= 1'b0;
    end else begin
      result  <= nextResult;
      satFlag <= strobe.doSat & clampHit;
    end
  end

  // R2: no processing means the selected operand passes unchanged
  assert_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doRound && !strobe.doSat) |=> (result == $past(picked) && !satFlag));

  // R3: rounding alone leaves the low bits cleared
  assert_round_low_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.doRound && !strobe.doSat) |=> (result[ROUND_BIT-1:0] == '0));

  // R4: saturated output always lies within the narrow range
  assert_sat_range_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.doSat |=> ($signed({result[DATA_W-1], result}) <= SAT_MAX &&
                      $signed({result[DATA_W-1], result}) >= SAT_MIN));

  // R5: no flag without saturation enabled
  assert_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe.doSat |=> !satFlag);

  // R8: synchronous reset clears both outputs
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (result == '0 && !satFlag));
endmodule

// File: rtl/round_sat_unit.sv
module round_sat_unit
  import round_sat_pkg::*;
#(
  parameter int DATA_W    = 44,
  parameter int ROUND_BIT = 8,
  parameter int SAT_WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] prodIn,
  input  logic [DATA_W-1:0] sum1In,
  input  logic [DATA_W-1:0] pipeIn,
  input  logic [DATA_W-1:0] sum2In,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              roundEn,
  input  logic              satEn,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);
  rs_strobe_t        strobe;
  logic [DATA_W-1:0] srcArr [NUM_SRC];

  always_comb begin
    srcArr[0] = prodIn;
    srcArr[1] = sum1In;
    srcArr[2] = pipeIn;
    srcArr[3] = sum2In;
  end

  round_sat_ctrl u_ctrl (
    .srcSel (srcSel),
    .roundEn(roundEn),
    .satEn  (satEn),
    .strobe (strobe)
  );

  round_sat_dp #(
    .DATA_W   (DATA_W),
    .ROUND_BIT(ROUND_BIT),
    .SAT_WIDTH(SAT_WIDTH)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .srcArr (srcArr),
    .strobe (strobe),
    .result (result),
    .satFlag(satFlag)
  );
endmodule

// File: tb/round_sat_unit_test.sv
module round_sat_unit_test;
  localparam int NV    = 13;
  localparam int VEC_W = 2 + 1 + 1 + 44 + 44 + 1;

  // {srcSel, roundEn, satEn, operand, expected result, expected flag}
  localparam logic [VEC_W-1:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 44'h00000001234, 44'h00000001234, 1'b0}, // R1 R2
    {2'd1, 1'b1, 1'b0, 44'h00000001280, 44'h00000001300, 1'b0}, // R3 half rounds up
    {2'd2, 1'b1, 1'b0, 44'h0000000127F, 44'h00000001200, 1'b0}, // R3 below half
    {2'd3, 1'b0, 1'b1, 44'h00100000000, 44'h0007FFFFFFF, 1'b1}, // R4 positive clamp
    {2'd0, 1'b0, 1'b1, 44'hF0000000000, 44'hFFF80000000, 1'b1}, // R4 negative clamp
    {2'd1, 1'b0, 1'b1, 44'h0007FFFFFFF, 44'h0007FFFFFFF, 1'b0}, // R5 at max
    {2'd2, 1'b0, 1'b1, 44'hFFF80000000, 44'hFFF80000000, 1'b0}, // R5 at min
    {2'd3, 1'b1, 1'b1, 44'h0007FFFFF80, 44'h0007FFFFFFF, 1'b1}, // R6 round then clamp
    {2'd0, 1'b1, 1'b0, 44'h7FFFFFFFF80, 44'h80000000000, 1'b0}, // R3 wraps
    {2'd1, 1'b1, 1'b1, 44'h7FFFFFFFF80, 44'h0007FFFFFFF, 1'b1}, // R6 carry clamped
    {2'd2, 1'b1, 1'b0, 44'hFFFFFFFFF80, 44'h00000000000, 1'b0}, // R3 negative half
    {2'd3, 1'b1, 1'b0, 44'hFFFFFFFFF7F, 44'hFFFFFFFFF00, 1'b0}, // R3 negative below half
    {2'd0, 1'b0, 1'b0, 44'h80000000000, 44'h80000000000, 1'b0}  // R5 no flag when off
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [43:0] prodIn = '0, sum1In = '0, pipeIn = '0, sum2In = '0;
  logic [1:0]  srcSel = '0;
  logic        roundEn = 1'b0, satEn = 1'b0;
  logic [43:0] result;
  logic        satFlag;
  int          nRun = 0, nFail = 0;
  logic [43:0] prevRes;
  logic        prevFlag;

  always #5 clk = ~clk;

  round_sat_unit uut (
    .clk(clk), .rst(rst), .prodIn(prodIn), .sum1In(sum1In), .pipeIn(pipeIn),
    .sum2In(sum2In), .srcSel(srcSel), .roundEn(roundEn), .satEn(satEn),
    .result(result), .satFlag(satFlag)
  );

  task automatic chk(input string req, input logic [43:0] act, input logic [43:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // operand on the selected source, distinct junk elsewhere (R1)
  task automatic drive(input logic [1:0] sel, input logic rn, input logic st,
                       input logic [43:0] x);
    prodIn  = 44'h0A5A5A5A5A5;
    sum1In  = 44'h05A5A5A5A5A;
    pipeIn  = 44'h7FFFFFFFFFF;
    sum2In  = 44'h80000000001;
    case (sel)
      2'd0: prodIn = x;
      2'd1: sum1In = x;
      2'd2: pipeIn = x;
      default: sum2In = x;
    endcase
    srcSel = sel; roundEn = rn; satEn = st;
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset result", result, 44'h0);
    chk("R8 reset flag", {43'h0, satFlag}, 44'h0);
    rst = 1'b0;
    prevRes = '0; prevFlag = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][92:91], VEC[v][90], VEC[v][89], VEC[v][88:45]);
      #1;
      chk("R7 holds until edge", result, prevRes);
      @(negedge clk);
      chk($sformatf("R1..vec%0d result", v), result, VEC[v][44:1]);
      chk($sformatf("R4 R5 vec%0d flag", v), {43'h0, satFlag}, {43'h0, VEC[v][0]});
      prevRes = VEC[v][44:1]; prevFlag = VEC[v][0];
    end

    // R8: reset mid-run with a flagged result present
    @(negedge clk);
    drive(2'd3, 1'b0, 1'b1, 44'h00100000000);
    @(negedge clk);
    chk("R4 flagged before reset", {43'h0, satFlag}, 44'h1);
    rst = 1'b1;
    #1;
    chk("R8 sync reset not before edge", result, 44'h0007FFFFFFF);
    @(negedge clk);
    chk("R8 result cleared", result, 44'h0);
    chk("R8 flag cleared", {43'h0, satFlag}, 44'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 resumes after reset", result, 44'h0007FFFFFFF);

    // R1: change only unselected source, output unchanged
    drive(2'd1, 1'b0, 1'b0, 44'h00000000042);
    @(negedge clk);
    prodIn = 44'h12345678901;
    sum2In = 44'hABCDEF01234;
    @(negedge clk);
    chk("R1 unselected ignored", result, 44'h00000000042);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule